// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a 16-bit free-running watchdog timer with one control register on a simple register bus. Software must write a fixed key byte in the upper half of every write. A write with any other key is discarded and counts as a fault: the block raises its reset request at once. On a read, the upper byte returns a different fixed constant, so a value read back cannot be written back unchanged and be accepted.

The control byte picks the counting clock enable, the expiry interval and the response. In watchdog mode an expiry pulses the reset request. In interval mode an expiry sets a sticky interrupt flag, and a dedicated acknowledge input clears it. Software can freeze the counter or zero it. On expiry the counter restarts from zero, so expiries repeat at the selected period for as long as counting goes on.

Top module: `guard_timer`

## Requirements
- R1: The control register answers at address 0x0120. A read there returns 0x69 in bits 15:8 and the stored control byte in bits 7:0. At any other address the read data is 0, and writes to other addresses have no effect.
- R2: A write to the register whose bits 15:8 equal 0x5A stores bits 7:0. The layout is: bit 7 hold, bit 6 pin edge select, bit 5 pin function select, bit 4 mode (0 watchdog, 1 interval), bit 3 counter clear, bit 2 clock-enable select, bits 1:0 interval select.
- R3: A write to the register with any other value in bits 15:8 leaves the control byte unchanged and drives `rst_req` high for exactly the next cycle.
- R4: A keyed write with bit 3 set zeroes the counter, and no expiry occurs in that cycle. Bit 3 is not stored and always reads 0.
- R5: While hold (bit 7) is 1, the counter does not advance and no expiry occurs.
- R6: Interval select 00, 01, 10 and 11 make an expiry happen on the 32768th, 8192nd, 512th and 64th counted tick after a restart. The counter then restarts from zero.
- R7: In watchdog mode an expiry drives `rst_req` high for exactly the next cycle.
- R8: In interval mode an expiry sets `irq` in the next cycle. `irq` stays set until a cycle with `irq_ack` high and no new expiry. If an expiry and an acknowledge happen in the same cycle, the expiry wins.
- R9: Clock-enable select 0 counts cycles with `tick_a` high, and select 1 counts cycles with `tick_b` high. The other enable is ignored.
- R10: After reset the control byte is 0x00 (watchdog mode, longest interval, `tick_a`), the counter is 0, and `rst_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 16 | Write data (key byte in bits 15:8) |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| tick_a | input | 1 | First counting clock enable |
| tick_b | input | 1 | Second counting clock enable |
| irq_ack | input | 1 | Clears the interval interrupt flag |
| rst_req | output | 1 | One-cycle reset request |
| irq | output | 1 | Sticky interval interrupt |

## Verification
The counter value is never visible on the ports. A wrong count, a missed clear or a tick slipping through during hold shows up only as an expiry at the wrong time, so the error appears as late as one full interval afterwards. The longest interval is 32768 ticks. The bench therefore measures the exact cycle distance between reset requests for every interval. It also compares `rst_req`, `irq` and the read-back byte every cycle against a behavioural model. A corrupted control byte shows up on the next read, and a lost key check shows up one cycle after the write.

// File: rtl/guard_pkg.sv
package guard_pkg;

    typedef struct packed {
        logic       hold;
        logic       pin_edge;
        logic       pin_func;
        logic       intv_mode;
        logic       clr;
        logic       use_b;
        logic [1:0] span;
    } guard_ctl_t;

    // ticks until expiry for a given interval select and counter width
    function automatic logic [31:0] span_limit(input logic [1:0] sel, input int cnt_w);
        case (sel)
            2'd0:    return 32'd1 << (cnt_w - 1);
            2'd1:    return 32'd1 << (cnt_w - 3);
            2'd2:    return 32'd1 << (cnt_w - 7);
            default: return 32'd1 << (cnt_w - 10);
        endcase
    endfunction

endpackage

// File: rtl/guard_regs.sv
module guard_regs
    import guard_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0120,
    parameter logic [7:0]  KEY_WR    = 8'h5A,
    parameter logic [7:0]  KEY_RD    = 8'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    output logic [15:0]       bus_rdata,
    output guard_ctl_t        ctl,
    output logic              clr_pulse,
    output logic              bad_key
);

    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(BASE_ADDR);

    typedef struct packed {
        guard_ctl_t ctl;
    } regs_state_t;

    regs_state_t st_d, st_q;
    logic        hit;
    logic        key_ok;
    guard_ctl_t  wr_val;

    always_comb begin
        hit       = (bus_addr == HIT_ADDR);
        key_ok    = (bus_wdata[15:8] == KEY_WR);
        wr_val    = guard_ctl_t'(bus_wdata[7:0]);
        wr_val.clr = 1'b0;
        st_d      = st_q;
        clr_pulse = 1'b0;
        bad_key   = 1'b0;
        if (bus_we && hit) begin
            if (key_ok) begin
                st_d.ctl  = wr_val;
                clr_pulse = bus_wdata[3];
            end else begin
                bad_key   = 1'b1;
            end
        end
        bus_rdata = hit ? {KEY_RD, st_q.ctl} : 16'h0000;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctl = st_q.ctl;

endmodule

// File: rtl/guard_counter.sv
module guard_counter
    import guard_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             use_b,
    input  logic [1:0]       span,
    input  logic             clr_pulse,
    input  logic             tick_a,
    input  logic             tick_b,
    output logic             expire,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t  st_d, st_q;
    logic        step;
    logic [31:0] limit;

    always_comb begin
        step   = !hold && (use_b ? tick_b : tick_a);
        limit  = span_limit(span, CNT_W);
        expire = step && !clr_pulse && (32'(st_q.cnt) >= (limit - 32'd1));
        st_d   = st_q;
        if (clr_pulse || expire) st_d.cnt = '0;
        else if (step)           st_d.cnt = st_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/guard_event.sv
module guard_event (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic intv_mode,
    input  logic bad_key,
    input  logic irq_ack,
    output logic rst_req,
    output logic irq
);

    typedef struct packed {
        logic rst_req;
        logic irq;
    } ev_state_t;

    ev_state_t st_d, st_q;

    always_comb begin
        st_d.rst_req = bad_key || (expire && !intv_mode);
        if (expire && intv_mode) st_d.irq = 1'b1;
        else if (irq_ack)        st_d.irq = 1'b0;
        else                     st_d.irq = st_q.irq;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_req = st_q.rst_req;
    assign irq     = st_q.irq;

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0120,
    parameter logic [7:0]  KEY_WR    = 8'h5A,
    parameter logic [7:0]  KEY_RD    = 8'h69,
    parameter int          CNT_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    input  logic              bus_we,
    output logic [15:0]       bus_rdata,
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic              irq_ack,
    output logic              rst_req,
    output logic              irq
);

    guard_ctl_t       ctl;
    logic [7:0]       ctl_q;
    logic [CNT_W-1:0] cnt_q;
    logic             clr_pulse;
    logic             bad_key;
    logic             expire;

    guard_regs #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .KEY_WR(KEY_WR), .KEY_RD(KEY_RD)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .ctl(ctl),
        .clr_pulse(clr_pulse), .bad_key(bad_key)
    );

    guard_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(ctl.hold), .use_b(ctl.use_b),
        .span(ctl.span), .clr_pulse(clr_pulse), .tick_a(tick_a),
        .tick_b(tick_b), .expire(expire), .cnt(cnt_q)
    );

    guard_event u_ev (
        .clk(clk), .rst_n(rst_n), .expire(expire), .intv_mode(ctl.intv_mode),
        .bad_key(bad_key), .irq_ack(irq_ack), .rst_req(rst_req), .irq(irq)
    );

    assign ctl_q = ctl;

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_ADDR = 16'h0120,
    parameter logic [7:0]  KEY_WR    = 8'h5A,
    parameter logic [7:0]  KEY_RD    = 8'h69,
    parameter int          CNT_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              bus_we,
    input logic [7:0]        rdata_hi,
    input logic              irq_ack,
    input logic              rst_req,
    input logic              irq,
    input logic [7:0]        ctl_q,
    input logic [CNT_W-1:0]  cnt_q
);

    logic hit_wr;
    logic good_wr;
    logic bad_wr;
    assign hit_wr  = bus_we && (bus_addr == ADDR_W'(BASE_ADDR));
    assign good_wr = hit_wr && (bus_wdata[15:8] == KEY_WR);
    assign bad_wr  = hit_wr && (bus_wdata[15:8] != KEY_WR);

    // R1: upper read byte is the fixed constant
    a_r1_read_key: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(BASE_ADDR)) |-> (rdata_hi == KEY_RD));

    // R2: keyed write stores the low byte, clear bit dropped
    a_r2_key_store: assert property (@(posedge clk) disable iff (!rst_n)
        good_wr |=> (ctl_q == ($past(bus_wdata[7:0]) & 8'hF7)));

    // R3: wrong key raises reset request and is not stored
    a_r3_bad_key_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> rst_req);
    a_r3_bad_key_kept: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> $stable(ctl_q));

    // R4: clear zeroes the counter
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (good_wr && bus_wdata[3]) |=> (cnt_q == '0));

    // R5: hold freezes the counter
    a_r5_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[7] && !hit_wr) |=> $stable(cnt_q));

    // R8: interrupt flag is sticky without acknowledge
    a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

endmodule

bind guard_timer guard_timer_chk #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .KEY_WR(KEY_WR),
    .KEY_RD(KEY_RD), .CNT_W(CNT_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .rdata_hi(bus_rdata[15:8]), .irq_ack(irq_ack),
    .rst_req(rst_req), .irq(irq), .ctl_q(ctl_q), .cnt_q(cnt_q)
);

// File: tb/test_guard_timer.sv
module test_guard_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0120;
    logic [15:0] bus_wdata = 16'h0000;
    logic        bus_we = 1'b0;
    logic [15:0] bus_rdata;
    logic        tick_a = 1'b0;
    logic        tick_b = 1'b0;
    logic        irq_ack = 1'b0;
    logic        rst_req;
    logic        irq;

    guard_timer i_guard_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .tick_a(tick_a), .tick_b(tick_b),
        .irq_ack(irq_ack), .rst_req(rst_req), .irq(irq)
    );

    always #5 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int pat_a = 0;
    int pat_b = 0;
    int rst_cnt = 0;
    int rst_last = 0;
    int rst_prev = 0;
    bit done = 1'b0;

    // behavioural reference model
    logic [7:0] m_ctl = 8'h00;
    int         m_cnt = 0;
    bit         m_rst = 1'b0;
    bit         m_irq = 1'b0;

    function automatic int lim_of(input logic [1:0] s);
        int t[4] = '{32768, 8192, 512, 64};
        return t[s];
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            bit wr, good, bad, step, clr, ex;
            wr   = bus_we && (bus_addr == 16'h0120);
            good = wr && (bus_wdata[15:8] == 8'h5A);
            bad  = wr && !good;
            clr  = good && bus_wdata[3];
            step = !m_ctl[7] && (m_ctl[2] ? tick_b : tick_a);
            ex   = step && !clr && (m_cnt >= lim_of(m_ctl[1:0]) - 1);
            m_rst = bad || (ex && !m_ctl[4]);
            if (ex && m_ctl[4]) m_irq = 1'b1;
            else if (irq_ack)   m_irq = 1'b0;
            if (clr || ex)  m_cnt = 0;
            else if (step)  m_cnt = m_cnt + 1;
            if (good) m_ctl = bus_wdata[7:0] & 8'hF7;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison and pulse monitor, at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            logic [15:0] er;
            er = (bus_addr == 16'h0120) ? {8'h69, m_ctl} : 16'h0000;
            if (bus_rdata !== er) check(0, "R1 R2 read data", bus_rdata, er);
            if (rst_req !== m_rst) check(0, "R3 R7 rst_req", rst_req, m_rst);
            if (irq !== m_irq) check(0, "R8 irq", irq, m_irq);
            if (rst_req) begin
                rst_cnt++;
                rst_prev = rst_last;
                rst_last = cyc;
            end
        end
        #1;
        tick_a = (pat_a == 1) || (pat_a == 2 && cyc[0]);
        tick_b = (pat_b == 1) || (pat_b == 2 && cyc[0]);
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); #2;
        bus_we = 1'b0; bus_addr = 16'h0120;
    endtask

    task automatic ack();
        @(negedge clk); #2; irq_ack = 1'b1;
        @(negedge clk); #2; irq_ack = 1'b0;
    endtask

    task automatic wait_pulses(input int n);
        int base;
        base = rst_cnt;
        while (rst_cnt < base + n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #150000000;
        check(0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int n0;
        idle(3);
        #2 rst_n = 1'b1;
        idle(2);
        // R10 reset state
        check(bus_rdata == 16'h6900, "R10 reset read", bus_rdata, 16'h6900);
        check(!rst_req && !irq, "R10 outputs low", {rst_req, irq}, 0);

        // R1 other address reads zero and ignores writes
        @(negedge clk); #2 bus_addr = 16'h0122;
        @(negedge clk);
        check(bus_rdata == 16'h0000, "R1 other address read", bus_rdata, 0);
        n0 = rst_cnt;
        bus_write(16'h0122, 16'h1234);
        idle(2);
        check(rst_cnt == n0, "R1 other address write ignored", rst_cnt - n0, 0);

        // R3 wrong key
        n0 = rst_cnt;
        bus_write(16'h0120, 16'h1213);
        idle(2);
        check(rst_cnt == n0 + 1, "R3 bad key single pulse", rst_cnt - n0, 1);
        check(bus_rdata == 16'h6900, "R3 bad key not stored", bus_rdata, 16'h6900);

        // R2 R6 R8 interval mode, 64 ticks on tick_a
        bus_write(16'h0120, 16'h5A73);
        check(bus_rdata == 16'h6973, "R2 keyed store", bus_rdata, 16'h6973);
        pat_a = 1;
        idle(62);
        check(irq == 1'b0, "R6 no expiry before 64 ticks", irq, 0);
        idle(3);
        check(irq == 1'b1, "R8 irq after 64 ticks", irq, 1);
        // R5 hold then acknowledge
        bus_write(16'h0120, 16'h5A93);
        idle(100);
        check(irq == 1'b1, "R8 irq sticky", irq, 1);
        ack();
        idle(1);
        check(irq == 1'b0, "R8 ack clears", irq, 0);
        idle(200);
        check(irq == 1'b0, "R5 hold freezes", irq, 0);

        // R4 clear restarts the full interval
        bus_write(16'h0120, 16'h5A1B);
        check(bus_rdata == 16'h6913, "R4 clear reads 0", bus_rdata, 16'h6913);
        idle(60);
        check(irq == 1'b0, "R4 counter zeroed", irq, 0);
        idle(8);
        check(irq == 1'b1, "R4 expiry after clear", irq, 1);

        // R9 select tick_b; tick_a ignored
        bus_write(16'h0120, 16'h5A97);
        ack();
        bus_write(16'h0120, 16'h5A1F);
        idle(200);
        check(irq == 1'b0, "R9 tick_a ignored", irq, 0);
        pat_b = 2;
        idle(140);
        check(irq == 1'b1, "R9 tick_b counts", irq, 1);
        pat_b = 0;
        bus_write(16'h0120, 16'h5A80);
        ack();

        // R7 R6 watchdog intervals, measured as pulse spacing
        bus_write(16'h0120, 16'h5A0B);
        wait_pulses(2);
        check(rst_last - rst_prev == 64, "R7 watchdog 64", rst_last - rst_prev, 64);
        bus_write(16'h0120, 16'h5A0A);
        wait_pulses(2);
        check(rst_last - rst_prev == 512, "R6 interval 512", rst_last - rst_prev, 512);
        bus_write(16'h0120, 16'h5A09);
        wait_pulses(2);
        check(rst_last - rst_prev == 8192, "R6 interval 8192", rst_last - rst_prev, 8192);
        bus_write(16'h0120, 16'h5A08);
        wait_pulses(2);
        check(rst_last - rst_prev == 32768, "R6 interval 32768", rst_last - rst_prev, 32768);
        idle(2);
        finish_run();
    end

endmodule